// File: doc/BRIEF.md
# Queue Pointer Controller

This block keeps a read pointer and a write pointer for each of a set of hardware queues. Software and on-chip agents never write absolute pointer values. They write small increments into a queue's register window, and the block adds them to the chosen pointer modulo the queue's configured size. Status reads return either pointer together with sticky overflow, underflow and bad-increment flags. A per-queue non-empty output lets downstream logic see at once which queues hold work.

The register bus is a plain 32-bit single-cycle interface with write enable, read enable, address and data. Read data is registered, so it appears one clock after the read strobe. Each queue owns a 0x800-byte window. The queue region starts at offset 0x80000, and the queue index comes from address bits 18:11.

Top module: `qptr_ctrl`

## Requirements
- R1: After reset, every pointer is 0, every queue size code is 8 (256 entries), all flags are clear, bus_rdata is 0 and every q_nonempty bit is 0.
- R2: Address bit 19 set selects the queue region. Bits 18:11 give the queue index and bits 10:0 give the window offset. An index at or above NUM_Q is unmapped.
- R3: A write at offset 0x000 adds bus_wdata[5:0] to the read pointer, and a write at offset 0x004 adds it to the write pointer. Both additions wrap modulo 2^size_code.
- R4: A read at offset 0x008 returns the read pointer in bits 17:0, and a read at offset 0x00C returns the write pointer in bits 17:0. Both reads report overflow in bit 31, underflow in bit 30 and the bad-increment flag in bit 29. All read data appears on the clock edge after the read strobe.
- R5: An add write whose data exceeds 0x3F leaves both pointers unchanged and sets the sticky bad-increment flag.
- R6: A write-pointer add that would bring the occupancy ((wptr-rptr) mod size) above size-1 sets the sticky overflow flag, and the pointer still advances.
- R7: A read-pointer add larger than the current occupancy sets the sticky underflow flag, and the pointer still advances.
- R8: A write at offset 0x014 clears overflow where data bit 0 is 1, underflow where data bit 1 is 1 and the bad-increment flag where data bit 2 is 1. No other operation clears a flag.
- R9: A write at offset 0x010 with a size code in bits 4:0 between 8 and 18 sets that size and zeroes both pointers. Any other code is ignored. A read at 0x010 returns the code.
- R10: q_nonempty[n] is 1 exactly when queue n's pointers differ, and it is valid on the clock edge that applies the add.
- R11: A read of an unmapped address or offset returns 0. A write to one changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (20) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| q_nonempty | output | NUM_Q (8) | Per-queue pointers-differ indication |

## Verification
A write changes pointer state and q_nonempty on the same clock edge that samples it. A read strobe produces bus_rdata on that same edge, so the result of a read issued in the cycle after a write already includes the write. The bench drives every input on the falling edge. A read pushes its expected word into a scoreboard queue, and a monitor pops and compares on the next falling edge, which is one edge after the strobe. q_nonempty is sampled on the falling edge that follows the write that should change it.

// File: rtl/qptr_pkg.sv
package qptr_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 11;

  localparam logic [OFF_W-1:0] OFF_ADD_RD = 11'h000;
  localparam logic [OFF_W-1:0] OFF_ADD_WR = 11'h004;
  localparam logic [OFF_W-1:0] OFF_ST_RD  = 11'h008;
  localparam logic [OFF_W-1:0] OFF_ST_WR  = 11'h00C;
  localparam logic [OFF_W-1:0] OFF_SIZE   = 11'h010;
  localparam logic [OFF_W-1:0] OFF_CLEAR  = 11'h014;

  localparam int BIT_OVF = 31;
  localparam int BIT_UDF = 30;
  localparam int BIT_ERR = 29;

  typedef enum logic [2:0] {
    OP_NONE, OP_ADD_RD, OP_ADD_WR, OP_ST_RD, OP_ST_WR, OP_SIZE, OP_CLEAR
  } qop_e;

  typedef struct packed {
    logic ovf;
    logic udf;
    logic err;
  } qflags_t;
endpackage

// File: rtl/qptr_decode.sv
module qptr_decode
  import qptr_pkg::*;
#(
  parameter int NUM_Q  = 8,
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [7:0]        qidx,
  output qop_e              op
);
  logic [OFF_W-1:0] off;
  logic             region;
  logic             idx_ok;

  assign off    = addr[OFF_W-1:0];
  assign qidx   = addr[18:11];
  assign region = addr[19];
  assign idx_ok = (32'(qidx) < NUM_Q);

  always_comb begin
    op = OP_NONE;
    if (region && idx_ok) begin
      case (off)
        OFF_ADD_RD: op = OP_ADD_RD;
        OFF_ADD_WR: op = OP_ADD_WR;
        OFF_ST_RD:  op = OP_ST_RD;
        OFF_ST_WR:  op = OP_ST_WR;
        OFF_SIZE:   op = OP_SIZE;
        OFF_CLEAR:  op = OP_CLEAR;
        default:    op = OP_NONE;
      endcase
    end
  end

  assign hit = (op != OP_NONE);
endmodule

// File: rtl/qptr_slot.sv
module qptr_slot
  import qptr_pkg::*;
#(
  parameter int PTR_W  = 18,
  parameter int LG_MIN = 8,
  parameter int INC_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  qop_e              op,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  rptr,
  output logic [PTR_W-1:0]  wptr,
  output logic [4:0]        lg,
  output qflags_t           flags,
  output logic              nonempty
);
  localparam int LG_MAX = PTR_W;

  logic [PTR_W-1:0] rptr_q, wptr_q, rptr_n, wptr_n;
  logic [4:0]       lg_q, lg_n;
  qflags_t          fl_q, fl_n;
  logic             ne_q;

  logic [PTR_W:0]   one_sh;
  logic [PTR_W-1:0] mask;
  logic [PTR_W-1:0] fill;
  logic [PTR_W:0]   fill_plus;
  logic [INC_W-1:0] inc;
  logic             bad;
  logic             lg_ok;

  assign one_sh    = (PTR_W+1)'(1) << lg_q;
  assign mask      = PTR_W'(one_sh - 1'b1);
  assign fill      = (wptr_q - rptr_q) & mask;
  assign inc       = wdata[INC_W-1:0];
  assign bad       = |wdata[DATA_W-1:INC_W];
  assign fill_plus = {1'b0, fill} + (PTR_W+1)'(inc);
  assign lg_ok     = (32'(wdata[4:0]) >= LG_MIN) && (32'(wdata[4:0]) <= LG_MAX);

  always_comb begin
    rptr_n = rptr_q;
    wptr_n = wptr_q;
    lg_n   = lg_q;
    fl_n   = fl_q;
    if (wr_en) begin
      case (op)
        OP_ADD_RD: begin
          if (bad) fl_n.err = 1'b1;
          else begin
            rptr_n = (rptr_q + PTR_W'(inc)) & mask;
            if (PTR_W'(inc) > fill) fl_n.udf = 1'b1;
          end
        end
        OP_ADD_WR: begin
          if (bad) fl_n.err = 1'b1;
          else begin
            wptr_n = (wptr_q + PTR_W'(inc)) & mask;
            if (fill_plus > {1'b0, mask}) fl_n.ovf = 1'b1;
          end
        end
        OP_SIZE: begin
          if (lg_ok) begin
            lg_n   = wdata[4:0];
            rptr_n = '0;
            wptr_n = '0;
          end
        end
        OP_CLEAR: begin
          if (wdata[0]) fl_n.ovf = 1'b0;
          if (wdata[1]) fl_n.udf = 1'b0;
          if (wdata[2]) fl_n.err = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q <= '0;
      wptr_q <= '0;
      lg_q   <= 5'(LG_MIN);
      fl_q   <= '0;
      ne_q   <= 1'b0;
    end else begin
      rptr_q <= rptr_n;
      wptr_q <= wptr_n;
      lg_q   <= lg_n;
      fl_q   <= fl_n;
      ne_q   <= (rptr_n != wptr_n);
    end
  end

  assign rptr     = rptr_q;
  assign wptr     = wptr_q;
  assign lg       = lg_q;
  assign flags    = fl_q;
  assign nonempty = ne_q;

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ((rptr_q & ~mask) == '0) && ((wptr_q & ~mask) == '0)); // R3
  AST_BIG_ADD_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (op == OP_ADD_WR || op == OP_ADD_RD) && bad)
      |=> ($stable(wptr_q) && $stable(rptr_q) && fl_q.err)); // R5
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_ADD_WR && !bad && fill_plus > {1'b0, mask}) |=> fl_q.ovf); // R6
  AST_UDF_SETS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_ADD_RD && !bad && PTR_W'(inc) > fill) |=> fl_q.udf); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fl_q.ovf && !(wr_en && op == OP_CLEAR && wdata[0])) |=> fl_q.ovf); // R8
  AST_NONEMPTY_MATCH: assert property (@(posedge clk) disable iff (rst)
    ne_q == (rptr_q != wptr_q)); // R10
endmodule

// File: rtl/qptr_ctrl.sv
module qptr_ctrl
  import qptr_pkg::*;
#(
  parameter int NUM_Q  = 8,
  parameter int ADDR_W = 20,
  parameter int PTR_W  = 18,
  parameter int LG_MIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_Q-1:0]  q_nonempty
);
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic        hit;
  logic [7:0]  qidx;
  qop_e        op;
  logic [QW-1:0] sel;

  logic [PTR_W-1:0] rptr_a [NUM_Q];
  logic [PTR_W-1:0] wptr_a [NUM_Q];
  logic [4:0]       lg_a   [NUM_Q];
  qflags_t          fl_a   [NUM_Q];
  logic [31:0]      rd_mux;
  logic [31:0]      rdata_q;

  qptr_decode #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit),
    .qidx (qidx),
    .op   (op)
  );

  assign sel = qidx[QW-1:0];

  for (genvar i = 0; i < NUM_Q; i++) begin : g_slot
    logic slot_wen;
    assign slot_wen = bus_wen && hit && (32'(qidx) == i);
    qptr_slot #(.PTR_W(PTR_W), .LG_MIN(LG_MIN)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (slot_wen),
      .op       (op),
      .wdata    (bus_wdata),
      .rptr     (rptr_a[i]),
      .wptr     (wptr_a[i]),
      .lg       (lg_a[i]),
      .flags    (fl_a[i]),
      .nonempty (q_nonempty[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (op)
      OP_ST_RD: begin
        rd_mux[PTR_W-1:0] = rptr_a[sel];
        rd_mux[BIT_OVF]   = fl_a[sel].ovf;
        rd_mux[BIT_UDF]   = fl_a[sel].udf;
        rd_mux[BIT_ERR]   = fl_a[sel].err;
      end
      OP_ST_WR: begin
        rd_mux[PTR_W-1:0] = wptr_a[sel];
        rd_mux[BIT_OVF]   = fl_a[sel].ovf;
        rd_mux[BIT_UDF]   = fl_a[sel].udf;
        rd_mux[BIT_ERR]   = fl_a[sel].err;
      end
      OP_SIZE: rd_mux[4:0] = lg_a[sel];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_ren) rdata_q <= rd_mux;
    else rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && !hit) |=> (bus_rdata == '0)); // R11
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_ren |=> (bus_rdata == '0)); // R4
endmodule

// File: tb/qptr_ctrl_test.sv
module qptr_ctrl_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wen = 0;
  logic        bus_ren = 0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  q_nonempty;

  int checks = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  qptr_ctrl uut (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .q_nonempty(q_nonempty)
  );

  function automatic logic [19:0] qa(int q, int off);
    return 20'h80000 | 20'(q << 11) | 20'(off);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wen = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 0;
  endtask

  task automatic rd(logic [19:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_ren = 1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_ren = 0;
  endtask

  always @(posedge clk) pend <= bus_ren;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check("scoreboard underrun", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 nonempty reset", 32'(q_nonempty), 32'd0);
    check("R1 rdata reset", bus_rdata, 32'd0);
    rd(qa(0, 'h8), 32'd0, "R1 rptr reset");
    rd(qa(5, 'h10), 32'd8, "R1 size code reset");

    // R3 basic adds on queue 0
    wr(qa(0, 'h4), 32'd5);
    check("R10 nonempty after wr add", 32'(q_nonempty[0]), 32'd1);
    wr(qa(0, 'h0), 32'd3);
    rd(qa(0, 'h8), 32'd3, "R3 rptr add");
    rd(qa(0, 'hC), 32'd5, "R4 wptr status");
    wr(qa(0, 'h0), 32'd2);
    check("R10 empty when equal", 32'(q_nonempty[0]), 32'd0);

    // R6 overflow with wrap on queue 1 (size 256)
    for (int k = 0; k < 4; k++) wr(qa(1, 'h4), 32'h3F);
    rd(qa(1, 'hC), 32'd252, "R3 wptr accumulates");
    wr(qa(1, 'h4), 32'd10);
    rd(qa(1, 'hC), 32'h8000_0006, "R6 overflow and wrap");
    rd(qa(1, 'h8), 32'h8000_0000, "R4 flag in rd status");
    wr(qa(1, 'h14), 32'd1);
    rd(qa(1, 'hC), 32'd6, "R8 overflow cleared");

    // R7 underflow on queue 2
    wr(qa(2, 'h4), 32'd5);
    wr(qa(2, 'h0), 32'd7);
    rd(qa(2, 'h8), 32'h4000_0007, "R7 underflow");
    wr(qa(2, 'h14), 32'd1);
    rd(qa(2, 'h8), 32'h4000_0007, "R8 udf kept by ovf clear");
    wr(qa(2, 'h14), 32'd2);
    rd(qa(2, 'h8), 32'd7, "R8 udf cleared");

    // R5 oversized increment on queue 3
    wr(qa(3, 'h4), 32'h40);
    rd(qa(3, 'hC), 32'h2000_0000, "R5 big add dropped");
    check("R5 nonempty unchanged", 32'(q_nonempty[3]), 32'd0);
    wr(qa(3, 'h14), 32'd4);
    rd(qa(3, 'hC), 32'd0, "R8 err cleared");

    // R9 size config on queue 0
    wr(qa(0, 'h4), 32'd9);
    wr(qa(0, 'h10), 32'd9);
    rd(qa(0, 'hC), 32'd0, "R9 size write zeroes pointers");
    check("R9 nonempty after size", 32'(q_nonempty[0]), 32'd0);
    for (int k = 0; k < 5; k++) wr(qa(0, 'h4), 32'h3F);
    rd(qa(0, 'hC), 32'd315, "R9 larger size no wrap");
    wr(qa(0, 'h10), 32'd20);
    rd(qa(0, 'h10), 32'd9, "R9 bad code ignored");
    rd(qa(0, 'hC), 32'd315, "R9 bad code keeps ptr");
    wr(qa(0, 'h10), 32'd18);
    for (int k = 0; k < 2; k++) wr(qa(0, 'h4), 32'h3F);
    rd(qa(0, 'hC), 32'd126, "R9 max size");

    // R2 R11 unmapped
    rd(qa(8, 'h8), 32'd0, "R2 index beyond NUM_Q");
    wr(qa(8, 'h4), 32'd1);
    wr(qa(4, 'h24), 32'd1);
    wr(20'h0_0804, 32'd1);
    rd(qa(4, 'h24), 32'd0, "R11 bad offset read");
    rd(20'h0_080C, 32'd0, "R2 region bit clear");
    rd(qa(4, 'hC), 32'd0, "R11 writes ignored");
    check("R11 no nonempty", 32'(q_nonempty[4]), 32'd0);
    wr(qa(7, 'h4), 32'd1);
    check("R2 last queue mapped", 32'(q_nonempty[7]), 32'd1);

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule